// File: doc/BRIEF.md
# Detector Trigger Busy Controller

This block decides, one clock at a time, whether a detector readout can take another trigger. It drives one busy line toward the central trigger processor. Low means the detector is ready (alive). High means the detector is busy. Two credit counters feed the decision. One counts free front-end event buffers. The other counts free intermediate ping-pong buffers.

A level-1 trigger that selects this detector raises busy. The level-2 decision then settles the line. A reject frees the line and touches no credit. An accept consumes one credit of each kind. After an accept the line stays busy only if no front-end buffer remains. Credits come back through two inputs. One is a per-cycle count of end-of-transfer indications from the readout links. The other is a strobe saying that a whole event fragment has arrived downstream.

A run-start strobe reloads both counters and clears a sticky error flag. That flag records any attempt to take a counter past zero or past its maximum. All inputs are single-cycle strobes in the block's clock domain.

Top module: `trig_busy_ctrl`

## Requirements
- R1: Reset or `run_start` loads `fe_free` with `FE_BUFS` and `pp_free` with 2, clears `err_flag`, and drives `busy` low, all visible one cycle after the strobe. `run_start` overrides every other input in the same cycle.
- R2: `l1_strobe` with `l1_in_mask` high raises `busy` on the next cycle and waits for a level-2 decision. `l0_strobe` alone has no effect on any output. `l1_strobe` with `l1_in_mask` low also has no effect on any output.
- R3: `l2r_strobe` while a level-2 decision is awaited drops `busy` on the next cycle. It leaves both counters unchanged.
- R4: `l2a_strobe` while a level-2 decision is awaited decrements both counters by one. After the update, `busy` goes low if `fe_free` is nonzero. If `fe_free` is zero, `busy` stays high; this is the held state.
- R5: Level-2 strobes that arrive while no decision is awaited are ignored.
- R6: `eot_count` is added to `fe_free` in the same cycle, but only when the current `pp_free` is greater than zero. When `pp_free` is zero the count is ignored.
- R7: `frag_done` adds one to `pp_free`.
- R8: Both counters saturate, `fe_free` in the range 0 to `FE_BUFS` and `pp_free` in the range 0 to 2. Any attempt to go beyond those bounds sets `err_flag`. The flag stays set until the next reset or `run_start`.
- R9: In the held state, `busy` drops on the same clock edge at which a credit return makes `fe_free` nonzero. That is one cycle after the returning strobe.
- R10: When a selecting level-1 trigger and a level-2 strobe arrive in the same cycle, the level-1 trigger wins and the level-2 strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_start | input | 1 | Run-start strobe, reloads credits |
| l0_strobe | input | 1 | Level-0 trigger strobe |
| l1_strobe | input | 1 | Level-1 trigger strobe |
| l1_in_mask | input | 1 | Level-1 trigger mask selects this detector |
| l2a_strobe | input | 1 | Level-2 accept strobe |
| l2r_strobe | input | 1 | Level-2 reject strobe |
| eot_count | input | $clog2(LINKS+1) | End-of-transfer indications this cycle |
| frag_done | input | 1 | Event fragment fully arrived downstream |
| busy | output | 1 | High = busy, low = alive |
| fe_free | output | $clog2(FE_BUFS+1) | Free front-end buffer credits |
| pp_free | output | 2 | Free ping-pong buffer credits |
| err_flag | output | 1 | Sticky counter bound violation |

## Verification
A wrong state or credit value shows up quickly at the ports. It affects `busy` and the counters on the first clock edge that follows the mistaken update. It also affects every later level-2 decision and credit return. A miscounted ping-pong credit shows up more slowly. It only appears when a later end-of-transfer is wrongly accepted or wrongly refused, so the bench drives long credit sequences. Those sequences empty and refill both counters, so such drift surfaces within a few events.

// File: rtl/trig_busy_pkg.sv
package trig_busy_pkg;

    // Ping-pong depth per readout path
    localparam int PP_SLOTS = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,  // alive
        ST_AWAIT = 2'd1,  // busy, waiting for level-2 decision
        ST_HOLD  = 2'd2   // busy, no front-end credit left
    } busy_state_t;

    typedef struct packed {
        logic l1_hit;
        logic accept;
        logic reject;
    } trig_ev_t;

    function automatic logic is_busy(busy_state_t s);
        return s != ST_IDLE;
    endfunction

endpackage

// File: rtl/trig_busy_credit.sv
module trig_busy_credit #(
    parameter int W   = 3,
    parameter int AW  = 4,
    parameter int MAX = 4
) (
    input  logic          clk,
    input  logic          load,
    input  logic [AW-1:0] add,
    input  logic          add_en,
    input  logic          sub,
    output logic [W-1:0]  count,
    output logic [W-1:0]  nxt,
    output logic          bound_err
);
    int sum;

    always_comb begin
        sum = int'(count) + (add_en ? int'(add) : 0) - (sub ? 1 : 0);
        bound_err = 1'b0;
        if (sum > MAX) begin
            nxt = W'(MAX);
            bound_err = 1'b1;
        end else if (sum < 0) begin
            nxt = '0;
            bound_err = 1'b1;
        end else begin
            nxt = W'(sum);
        end
    end

    always_ff @(posedge clk) begin
        if (load) count <= W'(MAX);
        else      count <= nxt;
    end
endmodule

// File: rtl/trig_busy_fsm.sv
module trig_busy_fsm
    import trig_busy_pkg::*;
(
    input  logic        clk,
    input  logic        load,
    input  logic        l1_strobe,
    input  logic        l1_in_mask,
    input  logic        l2a_strobe,
    input  logic        l2r_strobe,
    input  logic        fe_next_nz,
    output trig_ev_t    ev,
    output busy_state_t state
);
    busy_state_t state_nx;

    always_comb begin
        ev.l1_hit = l1_strobe && l1_in_mask;
        ev.accept = (state == ST_AWAIT) && !ev.l1_hit && l2a_strobe;
        ev.reject = (state == ST_AWAIT) && !ev.l1_hit && !l2a_strobe && l2r_strobe;
    end

    always_comb begin
        state_nx = state;
        if (ev.l1_hit)                           state_nx = ST_AWAIT;
        else if (ev.accept)                      state_nx = fe_next_nz ? ST_IDLE : ST_HOLD;
        else if (ev.reject)                      state_nx = ST_IDLE;
        else if (state == ST_HOLD && fe_next_nz) state_nx = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (load) state <= ST_IDLE;
        else      state <= state_nx;
    end
endmodule

// File: rtl/trig_busy_ctrl.sv
module trig_busy_ctrl
    import trig_busy_pkg::*;
#(
    parameter int FE_BUFS = 4,
    parameter int LINKS   = 8,
    localparam int CW     = $clog2(FE_BUFS + 1),
    localparam int EW     = $clog2(LINKS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run_start,
    input  logic          l0_strobe,
    input  logic          l1_strobe,
    input  logic          l1_in_mask,
    input  logic          l2a_strobe,
    input  logic          l2r_strobe,
    input  logic [EW-1:0] eot_count,
    input  logic          frag_done,
    output logic          busy,
    output logic [CW-1:0] fe_free,
    output logic [1:0]    pp_free,
    output logic          err_flag
);
    logic          load;
    logic          unused_l0;
    trig_ev_t      ev;
    busy_state_t   state;
    logic [CW-1:0] fe_nxt;
    logic [1:0]    pp_nxt;
    logic          fe_err, pp_err;

    assign load      = rst || run_start;
    assign unused_l0 = l0_strobe;   // level-0 carries no credit action

    trig_busy_credit #(.W(CW), .AW(EW), .MAX(FE_BUFS)) u_fe (
        .clk      (clk),
        .load     (load),
        .add      (eot_count),
        .add_en   (pp_free != 2'd0),
        .sub      (ev.accept),
        .count    (fe_free),
        .nxt      (fe_nxt),
        .bound_err(fe_err)
    );

    trig_busy_credit #(.W(2), .AW(1), .MAX(PP_SLOTS)) u_pp (
        .clk      (clk),
        .load     (load),
        .add      (frag_done),
        .add_en   (1'b1),
        .sub      (ev.accept),
        .count    (pp_free),
        .nxt      (pp_nxt),
        .bound_err(pp_err)
    );

    trig_busy_fsm u_fsm (
        .clk       (clk),
        .load      (load),
        .l1_strobe (l1_strobe),
        .l1_in_mask(l1_in_mask),
        .l2a_strobe(l2a_strobe),
        .l2r_strobe(l2r_strobe),
        .fe_next_nz(fe_nxt != '0),
        .ev        (ev),
        .state     (state)
    );

    always_ff @(posedge clk) begin
        if (load)                  err_flag <= 1'b0;
        else if (fe_err || pp_err) err_flag <= 1'b1;
    end

    assign busy = is_busy(state);

    logic [1:0] unused_ppn;
    assign unused_ppn = pp_nxt;
endmodule

// File: rtl/trig_busy_chk.sv
module trig_busy_chk
    import trig_busy_pkg::*;
#(
    parameter int FE_BUFS = 4,
    parameter int CW = 3,
    parameter int EW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          run_start,
    input logic          l1_strobe,
    input logic          l1_in_mask,
    input logic          l2a_strobe,
    input logic          l2r_strobe,
    input logic [EW-1:0] eot_count,
    input logic          frag_done,
    input logic          busy,
    input logic [CW-1:0] fe_free,
    input logic [1:0]    pp_free,
    input logic          err_flag,
    input busy_state_t   state
);
    a_r1_run_start: assert property (@(posedge clk) disable iff (rst)
        run_start |=> (fe_free == CW'(FE_BUFS)) && (pp_free == 2'd2) && !busy && !err_flag);

    a_r2_l1_busy: assert property (@(posedge clk) disable iff (rst)
        (l1_strobe && l1_in_mask && !run_start) |=> busy);

    a_r3_reject_keeps: assert property (@(posedge clk) disable iff (rst)
        (state == ST_AWAIT && l2r_strobe && !l2a_strobe && !l1_strobe && !run_start
         && eot_count == '0 && !frag_done)
        |=> !busy && $stable(fe_free) && $stable(pp_free));

    a_r4_accept_dec: assert property (@(posedge clk) disable iff (rst)
        (state == ST_AWAIT && l2a_strobe && !l1_strobe && !run_start
         && eot_count == '0 && fe_free != '0)
        |=> fe_free == $past(fe_free) - CW'(1));

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (fe_free <= CW'(FE_BUFS)) && (pp_free <= 2'd2));

    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (err_flag && !run_start) |=> err_flag);

    a_r9_hold_release: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && !run_start && !l1_strobe && eot_count != '0 && pp_free != 2'd0)
        |=> !busy);
endmodule

bind trig_busy_ctrl trig_busy_chk #(.FE_BUFS(FE_BUFS), .CW(CW), .EW(EW)) u_chk (
    .clk(clk), .rst(rst), .run_start(run_start), .l1_strobe(l1_strobe),
    .l1_in_mask(l1_in_mask), .l2a_strobe(l2a_strobe), .l2r_strobe(l2r_strobe),
    .eot_count(eot_count), .frag_done(frag_done), .busy(busy), .fe_free(fe_free),
    .pp_free(pp_free), .err_flag(err_flag), .state(state)
);

// File: tb/sim_trig_busy_ctrl.sv
module sim_trig_busy_ctrl;
    localparam int FE_BUFS = 4;
    localparam int LINKS   = 8;
    localparam int CW = $clog2(FE_BUFS + 1);
    localparam int EW = $clog2(LINKS + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run_start = 0, l0_strobe = 0, l1_strobe = 0, l1_in_mask = 0;
    logic l2a_strobe = 0, l2r_strobe = 0, frag_done = 0;
    logic [EW-1:0] eot_count = '0;
    logic busy, err_flag;
    logic [CW-1:0] fe_free;
    logic [1:0] pp_free;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    // reference model: 0 idle, 1 awaiting level-2, 2 held
    int m_fe, m_pp, m_st, m_err;

    always #2.5 clk = ~clk;

    trig_busy_ctrl #(.FE_BUFS(FE_BUFS), .LINKS(LINKS)) u0 (
        .clk(clk), .rst(rst), .run_start(run_start), .l0_strobe(l0_strobe),
        .l1_strobe(l1_strobe), .l1_in_mask(l1_in_mask), .l2a_strobe(l2a_strobe),
        .l2r_strobe(l2r_strobe), .eot_count(eot_count), .frag_done(frag_done),
        .busy(busy), .fe_free(fe_free), .pp_free(pp_free), .err_flag(err_flag)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst || run_start) begin
            m_fe = FE_BUFS; m_pp = 2; m_st = 0; m_err = 0;
        end else begin
            bit hit, acc, rej;
            int nf, np;
            hit = l1_strobe && l1_in_mask;
            acc = (m_st == 1) && !hit && l2a_strobe;
            rej = (m_st == 1) && !hit && !l2a_strobe && l2r_strobe;
            nf = m_fe + ((m_pp > 0) ? int'(eot_count) : 0) - (acc ? 1 : 0);
            np = m_pp + (frag_done ? 1 : 0) - (acc ? 1 : 0);
            if (nf > FE_BUFS) begin nf = FE_BUFS; m_err = 1; end
            if (nf < 0)       begin nf = 0;       m_err = 1; end
            if (np > 2)       begin np = 2;       m_err = 1; end
            if (np < 0)       begin np = 0;       m_err = 1; end
            if (hit)                      m_st = 1;
            else if (acc)                 m_st = (nf > 0) ? 0 : 2;
            else if (rej)                 m_st = 0;
            else if (m_st == 2 && nf > 0) m_st = 0;
            m_fe = nf; m_pp = np;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R2 busy vs model", int'(busy), (m_st != 0) ? 1 : 0);
            check("R6 fe_free vs model", int'(fe_free), m_fe);
            check("R7 pp_free vs model", int'(pp_free), m_pp);
            check("R8 err_flag vs model", int'(err_flag), m_err);
        end
    end

    // one-cycle strobe set on a falling edge; outputs are current on return
    task automatic pulse(input bit p0, input bit p1, input bit mk, input bit pa,
                         input bit pr, input bit rs, input bit fd, input int eot);
        @(negedge clk);
        l0_strobe = p0; l1_strobe = p1; l1_in_mask = mk; l2a_strobe = pa;
        l2r_strobe = pr; run_start = rs; frag_done = fd; eot_count = EW'(eot);
        @(negedge clk);
        l0_strobe = 0; l1_strobe = 0; l1_in_mask = 0; l2a_strobe = 0;
        l2r_strobe = 0; run_start = 0; frag_done = 0; eot_count = '0;
    endtask

    task automatic gap(input int n);
        repeat (n) @(negedge clk);
    endtask

    // scaled timing: L0 -> L1 11 cycles, L1 -> L2 200 cycles
    task automatic event_accept();
        pulse(1,0,0,0,0,0,0,0); gap(11);
        pulse(0,1,1,0,0,0,0,0); gap(200);
        pulse(0,0,0,1,0,0,0,0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 reset fe", int'(fe_free), FE_BUFS);
        check("R1 reset pp", int'(pp_free), 2);
        check("R1 reset busy", int'(busy), 0);

        pulse(1,0,0,0,0,0,0,0);
        check("R2 L0 alone", int'(busy), 0);
        pulse(0,1,0,0,0,0,0,0);
        check("R2 L1 unmasked", int'(busy), 0);
        pulse(0,1,1,0,0,0,0,0);
        check("R2 L1 masked", int'(busy), 1);
        gap(200);
        pulse(0,0,0,0,1,0,0,0);
        check("R3 reject busy", int'(busy), 0);
        check("R3 reject fe", int'(fe_free), FE_BUFS);
        pulse(0,0,0,1,0,0,0,0);
        check("R5 stray accept", int'(fe_free), FE_BUFS);
        pulse(0,0,0,0,1,0,0,0);
        check("R5 stray reject", int'(busy), 0);

        event_accept();
        check("R4 accept fe", int'(fe_free), FE_BUFS-1);
        check("R4 accept pp", int'(pp_free), 1);
        check("R4 alive", int'(busy), 0);
        pulse(0,0,0,0,0,0,1,0);
        check("R7 frag", int'(pp_free), 2);
        event_accept(); pulse(0,0,0,0,0,0,1,0);
        event_accept(); pulse(0,0,0,0,0,0,1,0);
        event_accept();
        check("R4 held busy", int'(busy), 1);
        check("R4 held fe", int'(fe_free), 0);
        gap(4000);
        pulse(0,0,0,0,0,0,0,2);
        check("R9 release", int'(busy), 0);
        check("R9 fe", int'(fe_free), 2);

        pulse(0,1,1,0,0,1,0,0);
        check("R10 run_start wins", int'(busy), 0);
        check("R1 run_start fe", int'(fe_free), FE_BUFS);
        event_accept(); event_accept();
        check("R7 pp empty", int'(pp_free), 0);
        pulse(0,0,0,0,0,0,0,1);
        check("R6 eot ignored", int'(fe_free), FE_BUFS-2);
        pulse(0,0,0,0,0,0,1,0);
        pulse(0,0,0,0,0,0,0,1);
        check("R6 eot added", int'(fe_free), FE_BUFS-1);
        pulse(0,0,0,0,0,0,0,5);
        check("R8 saturate", int'(fe_free), FE_BUFS);
        check("R8 err set", int'(err_flag), 1);
        gap(20);
        check("R8 err sticky", int'(err_flag), 1);
        pulse(0,0,0,0,0,1,0,0);
        check("R8 err cleared", int'(err_flag), 0);

        pulse(0,1,1,0,0,0,0,0);
        pulse(0,1,1,0,1,0,0,0);
        check("R10 L1 over L2", int'(busy), 1);
        pulse(0,0,0,0,1,0,0,0);

        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            l0_strobe  = ($urandom % 8) == 0;
            l1_strobe  = ($urandom % 8) == 0;
            l1_in_mask = ($urandom % 4) != 0;
            l2a_strobe = ($urandom % 6) == 0;
            l2r_strobe = ($urandom % 6) == 0;
            frag_done  = ($urandom % 5) == 0;
            eot_count  = (($urandom % 4) == 0) ? EW'($urandom % (LINKS + 1)) : '0;
            run_start  = ($urandom % 200) == 0;
        end
        pulse(0,0,0,0,0,0,0,0);
        gap(2);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(5 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule